// File: doc/BRIEF.md
# Configurable ADC Serial Frame Formatter

This block turns parallel converter samples of a fixed native width into serial frames on one data lane. Each bit takes one clock, and a frame marker travels with the data. Two plain control pins set the bit order and a three-bit length code. Based on that code, each sample goes out at its native width, cut down to fewer bits, or padded with zeros to more bits. The sample always stays left-aligned in value: when a sample is cut, its low bits are dropped, and padding zeros are placed below its least significant bit.

Samples enter on a valid/ready stream port. A sample is taken on a clock edge where both `s_valid` and `s_ready` are high. `s_ready` goes high only when at most one bit of the current frame is left to emit, so frames can run back to back with no idle bit. While `s_ready` is low, the source must hold `s_data` and `s_valid` steady. The bit order and the length code are captured with the sample, so a change to them takes effect at a frame boundary and never in the middle of a frame.

Two channel controls act on the lane. The output-hold pin clears only the final output flop while framing carries on. The power-down pin resets all framing state, withdraws `s_ready` and drops the driver enable.

Top module: `adc_frame_serializer`

## Requirements
- R1: After reset, with power-down low, `ser_data` and `ser_frame` are 0, `s_ready` is 1 and `drv_enable` is 1.
- R2: With `ctl_lsb_first` low, the first bit of a frame is bit NATIVE_W-1 of the sample, and the following bits descend in significance.
- R3: With `ctl_lsb_first` high, the same set of frame bits is sent in reverse order, so the last bit is the sample MSB.
- R4: The frame length follows `ctl_len_code`: 3'b000 gives NATIVE_W bits (12 by default), 3'b001 gives 8, 3'b010 gives 10, 3'b011 gives 12, 3'b100 gives 14 and 3'b101 gives 16.
- R5: When the frame length is less than NATIVE_W, the sample's least significant bits are dropped and its most significant bits are kept.
- R6: When the frame length exceeds NATIVE_W, zeros fill the positions below the sample's LSB.
- R7: The reserved codes 3'b110 and 3'b111 give frames of NATIVE_W bits.
- R8: The bit order and length are sampled at the accepting edge. A change to them during a frame has no effect on that frame.
- R9: `ser_frame` is high on the first bit of each frame and low on every other bit and on idle cycles.
- R10: `s_ready` is high exactly when power-down is low and at most one bit of the current frame is left to emit. The first bit of an accepted sample appears on `ser_data` after the clock edge that follows the accepting edge, and consecutive frames leave no gap.
- R11: When `ch_out_hold` is high at an edge, `ser_data` and `ser_frame` are 0 after that edge. The frame keeps advancing, so the bits skipped during the hold are lost.
- R12: While `ch_power_down` is high, `drv_enable` and `s_ready` are 0. An edge with power-down high discards the frame in progress and leaves `ser_data` and `ser_frame` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Formatter can accept a sample |
| s_data | input | NATIVE_W | Converter sample |
| ctl_lsb_first | input | 1 | 1: least significant bit first; 0: most significant bit first |
| ctl_len_code | input | 3 | Frame-length code |
| ch_out_hold | input | 1 | Hold the output flop in reset |
| ch_power_down | input | 1 | Power the channel down and reset its logic |
| ser_data | output | 1 | Serial data lane |
| ser_frame | output | 1 | First-bit frame marker |
| drv_enable | output | 1 | Enable toward the line driver |

## Verification
The bench targets the points where a frame ends. A design that raises `s_ready` one bit too early drops the last bit of a frame, and one that raises it one bit too late leaves a gap between back-to-back frames. Frames with the 8-bit and 16-bit codes in both bit orders catch a design that cuts from the wrong end, pads on the wrong side, or reverses only the sample instead of the whole frame. The reserved codes catch a design that decodes them to some other length. Changing the controls in the middle of a frame catches a design that uses live control values. Output hold and power-down are applied in the middle of a frame: a wrong design either freezes the frame during a hold, or lets a stale tail of the frame continue after power-down.

// File: rtl/adcser_pkg.sv
package adcser_pkg;

  typedef enum logic [2:0] {
    LEN_NATIVE = 3'b000,
    LEN_8      = 3'b001,
    LEN_10     = 3'b010,
    LEN_12     = 3'b011,
    LEN_14     = 3'b100,
    LEN_16     = 3'b101,
    LEN_RSV_A  = 3'b110,
    LEN_RSV_B  = 3'b111
  } len_code_e;

  // Longest frame the shifter must hold: the native width or 16, whichever is larger.
  function automatic int unsigned frame_max(input int unsigned native_w);
    return (native_w > 16) ? native_w : 16;
  endfunction

  function automatic int unsigned cnt_bits(input int unsigned max_w);
    return $clog2(max_w + 1);
  endfunction

endpackage

// File: rtl/adcser_len_decode.sv
module adcser_len_decode
  import adcser_pkg::*;
#(
  parameter int unsigned NATIVE_W = 12,
  parameter int unsigned CNT_W    = 5
) (
  input  logic [2:0]       code,
  output logic [CNT_W-1:0] frame_len
);

  len_code_e sel;
  assign sel = len_code_e'(code);

  always_comb begin
    unique case (sel)
      LEN_8:   frame_len = CNT_W'(8);
      LEN_10:  frame_len = CNT_W'(10);
      LEN_12:  frame_len = CNT_W'(12);
      LEN_14:  frame_len = CNT_W'(14);
      LEN_16:  frame_len = CNT_W'(16);
      default: frame_len = CNT_W'(NATIVE_W); // native and both reserved codes
    endcase
  end

  // R4 R7: the decoded length is one of the legal frame sizes
  always_comb begin
    a_r7_len_legal: assert (frame_len == CNT_W'(NATIVE_W) || frame_len == CNT_W'(8) ||
                            frame_len == CNT_W'(10) || frame_len == CNT_W'(12) ||
                            frame_len == CNT_W'(14) || frame_len == CNT_W'(16));
  end

endmodule

// File: rtl/adcser_packer.sv
module adcser_packer #(
  parameter int unsigned NATIVE_W = 12,
  parameter int unsigned MAX_W    = 16,
  parameter int unsigned CNT_W    = 5
) (
  input  logic [NATIVE_W-1:0] sample,
  input  logic [CNT_W-1:0]    frame_len,
  input  logic                lsb_first,
  output logic [MAX_W-1:0]    word
);

  localparam int unsigned PAD_W = MAX_W - NATIVE_W;

  logic [MAX_W-1:0] aligned;
  logic [MAX_W-1:0] keep_mask;
  logic [MAX_W-1:0] msb_word;
  logic [MAX_W-1:0] reversed;
  logic [MAX_W-1:0] lsb_word;
  logic [CNT_W-1:0] rev_shift;

  // Left-align the sample: padding zeros sit below its LSB.
  generate
    if (PAD_W == 0) begin : g_no_pad
      assign aligned = sample;
    end else begin : g_pad
      assign aligned = {sample, {PAD_W{1'b0}}};
    end
  endgenerate

  // Keep the top frame_len bits, dropping the low bits when the frame is short.
  assign keep_mask = ~({MAX_W{1'b1}} >> frame_len);
  assign msb_word  = aligned & keep_mask;

  generate
    for (genvar i = 0; i < MAX_W; i++) begin : g_rev
      assign reversed[i] = aligned[MAX_W-1-i];
    end
  endgenerate

  // Reverse the whole kept window and left-align it so the frame's last bit goes out first.
  assign rev_shift = CNT_W'(MAX_W) - frame_len;
  assign lsb_word  = reversed << rev_shift;

  assign word = lsb_first ? lsb_word : msb_word;

endmodule

// File: rtl/adcser_shift_engine.sv
module adcser_shift_engine #(
  parameter int unsigned MAX_W = 16,
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             power_down,
  input  logic             out_hold,
  input  logic             load,
  input  logic [MAX_W-1:0] word,
  input  logic [CNT_W-1:0] frame_len,
  output logic             ready,
  output logic             ser_data,
  output logic             ser_frame
);

  logic [MAX_W-1:0] sh_q;
  logic [CNT_W-1:0] rem_q;
  logic             first_q;
  logic             bit_q;
  logic             frm_q;
  logic             emit;

  assign emit  = (rem_q != '0);
  assign ready = !power_down && (rem_q <= CNT_W'(1));

  // Framing state: reset by power-down, reloaded at the frame boundary only.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      rem_q   <= '0;
      first_q <= 1'b0;
    end else if (power_down) begin
      sh_q    <= '0;
      rem_q   <= '0;
      first_q <= 1'b0;
    end else if (load) begin
      sh_q    <= word;
      rem_q   <= frame_len;
      first_q <= 1'b1;
    end else if (emit) begin
      sh_q    <= sh_q << 1;
      rem_q   <= rem_q - CNT_W'(1);
      first_q <= 1'b0;
    end
  end

  // Final output flop: its own reset is the output hold.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 1'b0;
      frm_q <= 1'b0;
    end else if (power_down || out_hold || !emit) begin
      bit_q <= 1'b0;
      frm_q <= 1'b0;
    end else begin
      bit_q <= sh_q[MAX_W-1];
      frm_q <= first_q;
    end
  end

  assign ser_data  = bit_q;
  assign ser_frame = frm_q;

  // R11: a held output is quiet after the edge
  a_r11_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    out_hold |=> (!ser_data && !ser_frame));

  // R12: power-down empties the frame and silences the lane
  a_r12_pd_flush: assert property (@(posedge clk) disable iff (!rst_n)
    power_down |=> (!ser_data && !ser_frame && rem_q == '0));

  // R8: no reload while more than one bit is still pending
  a_r8_no_midframe_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_q > CNT_W'(1) && !power_down) |=> (rem_q == $past(rem_q) - CNT_W'(1)));

  // R9: the marker only follows a first bit
  a_r9_marker_first: assert property (@(posedge clk) disable iff (!rst_n)
    ser_frame |-> $past(first_q));

endmodule

// File: rtl/adc_frame_serializer.sv
module adc_frame_serializer
  import adcser_pkg::*;
#(
  parameter int unsigned NATIVE_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [NATIVE_W-1:0] s_data,
  input  logic                ctl_lsb_first,
  input  logic [2:0]          ctl_len_code,
  input  logic                ch_out_hold,
  input  logic                ch_power_down,
  output logic                ser_data,
  output logic                ser_frame,
  output logic                drv_enable
);

  localparam int unsigned MAX_W = frame_max(NATIVE_W);
  localparam int unsigned CNT_W = cnt_bits(MAX_W);

  logic [CNT_W-1:0] frame_len;
  logic [MAX_W-1:0] word;
  logic             load;

  assign load       = s_valid && s_ready;
  assign drv_enable = !ch_power_down;

  adcser_len_decode #(
    .NATIVE_W (NATIVE_W),
    .CNT_W    (CNT_W)
  ) u_len (
    .code      (ctl_len_code),
    .frame_len (frame_len)
  );

  adcser_packer #(
    .NATIVE_W (NATIVE_W),
    .MAX_W    (MAX_W),
    .CNT_W    (CNT_W)
  ) u_pack (
    .sample    (s_data),
    .frame_len (frame_len),
    .lsb_first (ctl_lsb_first),
    .word      (word)
  );

  adcser_shift_engine #(
    .MAX_W (MAX_W),
    .CNT_W (CNT_W)
  ) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .power_down (ch_power_down),
    .out_hold   (ch_out_hold),
    .load       (load),
    .word       (word),
    .frame_len  (frame_len),
    .ready      (s_ready),
    .ser_data   (ser_data),
    .ser_frame  (ser_frame)
  );

  // R12: a powered-down channel neither drives nor accepts
  a_r12_drv_off: assert property (@(posedge clk) disable iff (!rst_n)
    ch_power_down |-> (!drv_enable && !s_ready));

  // R10: an accepted sample always starts a frame one edge later
  a_r10_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !ch_power_down) |=> (u_eng.rem_q != '0 || ch_power_down));

endmodule

// File: tb/adc_frame_serializer_test.sv
module adc_frame_serializer_test;

  localparam int CLK_PERIOD = 10;
  localparam int N = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         s_valid = 1'b0;
  logic         s_ready;
  logic [N-1:0] s_data = '0;
  logic         ctl_lsb_first = 1'b0;
  logic [2:0]   ctl_len_code = 3'b000;
  logic         ch_out_hold = 1'b0;
  logic         ch_power_down = 1'b0;
  logic         ser_data;
  logic         ser_frame;
  logic         drv_enable;

  int    checks = 0;
  int    errors = 0;
  string req = "R1";
  bit    done = 1'b0;

  bit [1:0] q[$];   // {first, bit}
  logic     exp_d = 1'b0;
  logic     exp_f = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_frame_serializer #(.NATIVE_W(N)) uut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .ctl_lsb_first(ctl_lsb_first), .ctl_len_code(ctl_len_code),
    .ch_out_hold(ch_out_hold), .ch_power_down(ch_power_down),
    .ser_data(ser_data), .ser_frame(ser_frame), .drv_enable(drv_enable)
  );

  function automatic int len_of(input logic [2:0] c);
    case (c)
      3'b001: return 8;
      3'b010: return 10;
      3'b011: return 12;
      3'b100: return 14;
      3'b101: return 16;
      default: return N;
    endcase
  endfunction

  // Behavioural reference, one step per edge.
  always @(posedge clk) begin
    bit acc;
    bit [1:0] e;
    bit fb[$];
    int len;
    if (!rst_n || ch_power_down) begin
      q.delete();
      exp_d = 1'b0;
      exp_f = 1'b0;
    end else begin
      acc = s_valid && (q.size() <= 1);
      if (q.size() > 0) begin
        e = q.pop_front();
        exp_d = ch_out_hold ? 1'b0 : e[0];
        exp_f = ch_out_hold ? 1'b0 : e[1];
      end else begin
        exp_d = 1'b0;
        exp_f = 1'b0;
      end
      if (acc) begin
        len = len_of(ctl_len_code);
        fb.delete();
        for (int i = 0; i < len; i++) fb.push_back((i < N) ? s_data[N-1-i] : 1'b0);
        for (int i = 0; i < len; i++) begin
          e[0] = ctl_lsb_first ? fb[len-1-i] : fb[i];
          e[1] = (i == 0);
          q.push_back(e);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  // Compare on every falling edge, before the stimulus moves.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({req, " ser_data"}, ser_data, exp_d);
      chk({req, " R9 ser_frame"}, ser_frame, exp_f);
      chk("R10 s_ready", s_ready, !ch_power_down && (q.size() <= 1));
      chk("R12 drv_enable", drv_enable, !ch_power_down);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  // Offer one sample and return just after the edge that takes it; valid stays high.
  task automatic send(input logic [N-1:0] d, input logic [2:0] code, input logic lsb);
    s_data = d;
    ctl_len_code = code;
    ctl_lsb_first = lsb;
    s_valid = 1'b1;
    while (!s_ready) step(1);
    @(posedge clk);
    step(1);
  endtask

  task automatic idle(input int n);
    s_valid = 1'b0;
    step(n);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1: reset state at the ports
    chk("R1 ser_data", ser_data, 1'b0);
    chk("R1 ser_frame", ser_frame, 1'b0);
    chk("R1 s_ready", s_ready, 1'b1);
    chk("R1 drv_enable", drv_enable, 1'b1);

    req = "R2"; send(12'hA5C, 3'b000, 1'b0); idle(16);
    req = "R3"; send(12'hA5C, 3'b000, 1'b1); idle(16);
    req = "R4";
    for (int c = 1; c <= 5; c++) send(12'hC93 ^ 12'(c), 3'(c), 1'b0);
    idle(20);
    req = "R5"; send(12'hF0F, 3'b001, 1'b0); send(12'h3C1, 3'b001, 1'b1); idle(12);
    req = "R6"; send(12'h801, 3'b101, 1'b0); send(12'h801, 3'b101, 1'b1); idle(20);
    req = "R7"; send(12'h6B9, 3'b110, 1'b0); send(12'h6B9, 3'b111, 1'b1); idle(16);
    req = "R8";
    send(12'h9E7, 3'b101, 1'b0);
    s_valid = 1'b0;
    step(2);
    ctl_len_code = 3'b001;
    ctl_lsb_first = 1'b1;
    step(4);
    ctl_len_code = 3'b011;
    idle(16);
    req = "R10";
    send(12'h123, 3'b010, 1'b0); send(12'hFED, 3'b010, 1'b1); send(12'h5A5, 3'b000, 1'b0);
    idle(16);
    req = "R11";
    send(12'hFFF, 3'b100, 1'b0);
    s_valid = 1'b0;
    step(3);
    ch_out_hold = 1'b1;
    step(4);
    ch_out_hold = 1'b0;
    idle(16);
    req = "R12";
    send(12'hFFF, 3'b101, 1'b1);
    s_valid = 1'b0;
    step(4);
    ch_power_down = 1'b1;
    s_valid = 1'b1;
    step(4);
    ch_power_down = 1'b0;
    s_valid = 1'b0;
    step(3);
    send(12'h0F3, 3'b011, 1'b0); idle(16);
    req = "R4";
    for (int k = 0; k < 24; k++) begin
      send(N'($urandom), 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)));
      if (k % 3 == 0) idle(1 + (k % 5));
    end
    idle(20);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule